// File: doc/BRIEF.md
# Cascadable Dual Byte Timer

This block holds two 8-bit up-counters, a high byte and a low byte, together with a compare register and a toggling output pin for each. A mode bit in the control register selects between two arrangements. In the first, the bytes are chained into one 16-bit counter, with the high byte as the upper half. In the second, the two bytes run as separate 8-bit timers. Count pulses come from outside as a vector of one-cycle enable strobes, and each byte picks one strobe with its own select field. The block does not divide the clock itself.

In 16-bit mode a status bit can make the counter return to zero on a compare match. A wrap from 0xFFFF to 0x0000 sets a sticky overflow flag. That flag drives a request line, gated by an enable bit in the block and by an enable input from outside. Software reaches the counter through a byte-wide register port. In 16-bit mode, counter transfers pass through a byte-wide holding latch, so a 16-bit value is always read or loaded as one coherent snapshot.

Register addresses are: 0 counter high, 1 counter low, 2 compare high, 3 compare low, 4 control, 5 status. In the control register, bits [2:0] are the low select (`lsel`) and bits [6:4] are the high select (`hsel`). Bit 6 is the mode bit: 0 selects 16-bit mode and 1 selects split mode. In the status register, bit 7 is the overflow flag, bit 1 is the request enable and bit 0 is clear-on-match. A read returns `rdata_o` in the same cycle as `rd_en_i`. Read side effects and writes take effect at the next clock edge.

Top module: `twin_byte_timer`

## Requirements
- R1: After reset, both counter bytes, the compare registers, the control register, the status register, both toggle pins and `irq_o` are all 0.
- R2: In 16-bit mode (control bit 6 = 0), each strobe `tick_i[lsel]` adds 1 to the 16-bit value {high, low}, and a carry out of the low byte increments the high byte. Strobes on other indices leave the counter unchanged.
- R3: In split mode (control bit 6 = 1), the high byte counts on `tick_i[hsel]` and the low byte counts on `tick_i[lsel]`. Each byte wraps at 8 bits with no carry into the other, and reads and writes of either byte act on it directly.
- R4: In 16-bit mode with status bit 0 set, a count strobe that arrives while the counter equals {compare high, compare low} sets the counter to 0x0000 instead of incrementing it.
- R5: In 16-bit mode, a count strobe at 0xFFFF sets the overflow flag (status bit 7).
- R6: A status write with bit 7 = 0 clears the flag only if the flag was read as 1 since the last status write. Without that read, the write leaves the flag set. An overflow in the same cycle as the clearing write keeps the flag set.
- R7: `irq_o` is 1 exactly when the flag, status bit 1 and `irq_en_i` are all 1.
- R8: In 16-bit mode, reading address 0 returns the high byte and latches the low byte into the holding register in the same cycle. A later read of address 1 returns that latched byte.
- R9: In 16-bit mode, writing address 0 only fills the holding register. Writing address 1 then loads {held byte, written byte} into the counter at once.
- R10: In 16-bit mode, `tog_hi_o` inverts on each count strobe that arrives while the counter equals the 16-bit compare value. In split mode, `tog_hi_o` and `tog_lo_o` each invert on a strobe that arrives while their own byte equals its compare byte.
- R11: A counter write that loads a byte overrides a count strobe for that byte in the same cycle. The loaded value wins, and that strobe produces no toggle and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 8 | Pre-generated count enable strobes, one cycle each |
| irq_en_i | input | 1 | External qualifier of the request line |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (drives read side effects) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Overflow request |
| tog_hi_o | output | 1 | High half toggle output |
| tog_lo_o | output | 1 | Low half toggle output |

## Verification
A wrong count or a missed carry shows up at the register port at the next read. Because the bench checks the toggle pins after every single strobe, a bad compare shows up as a pin mismatch in the same cycle that the strobe is taken. Errors in the holding latch or in the flag's read-then-clear handshake are visible on the very next read, or on `irq_o` one cycle after the write. Long sweeps in both modes push the counters through byte carries, wraps and compare hits, and every result is compared against an arithmetic model kept in the bench.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CNT_HI = 3'd0,
    REG_CNT_LO = 3'd1,
    REG_CMP_HI = 3'd2,
    REG_CMP_LO = 3'd3,
    REG_CTRL   = 3'd4,
    REG_STAT   = 3'd5
  } reg_addr_e;

  localparam int STAT_OVF_BIT  = 7;
  localparam int STAT_IE_BIT   = 1;
  localparam int STAT_CCLR_BIT = 0;
  localparam int CTRL_HI_POS   = 4;
endpackage

// File: rtl/tbt_count_half.sv
module tbt_count_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         clr_en,
  input  logic         inc_en,
  output logic [W-1:0] value
);
  logic [W-1:0] value_q, value_d;

  always_comb begin
    value_d = value_q;
    if (load_en)     value_d = load_val;
    else if (clr_en) value_d = '0;
    else if (inc_en) value_d = value_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= value_d;
  end

  assign value = value_q;
endmodule

// File: rtl/tbt_match_toggle.sv
module tbt_match_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  output logic toggle_o
);
  logic tog_q, tog_d;

  always_comb tog_d = event_i ? ~tog_q : tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign toggle_o = tog_q;
endmodule

// File: rtl/tbt_ovf_status.sv
module tbt_ovf_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_stat_i,
  input  logic wr_stat_i,
  input  logic wr_zero_i,
  input  logic ie_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d, armed_q, armed_d;

  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    if (set_i)                                flag_d = 1'b1;
    else if (wr_stat_i && wr_zero_i && armed_q) flag_d = 1'b0;
    if (wr_stat_i)                            armed_d = 1'b0;
    else if (rd_stat_i && flag_q)             armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i & irq_en_i;
endmodule

// File: rtl/twin_byte_timer.sv
module twin_byte_timer #(
  parameter int N_TICK = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_TICK-1:0]         tick_i,
  input  logic                      irq_en_i,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  input  logic [2:0]                addr_i,
  input  logic [7:0]                wdata_i,
  output logic [7:0]                rdata_o,
  output logic                      irq_o,
  output logic                      tog_hi_o,
  output logic                      tog_lo_o
);
  import tbt_pkg::*;
  localparam int SEL_W  = $clog2(N_TICK);
  localparam int FULL_W = 2 * BYTE_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  reg_addr_e           addr_e;
  logic [BYTE_W-1:0]   cmp_h_q, cmp_h_d, cmp_l_q, cmp_l_d, temp_q, temp_d;
  logic [SEL_W-1:0]    hsel_q, hsel_d, lsel_q, lsel_d;
  logic                ovie_q, ovie_d, cclr_q, cclr_d;
  logic                split, tick_lo, tick_hi;
  logic                wr_hi, wr_lo, rd_hi, wr_stat, rd_stat;
  logic [FULL_W-1:0]   full_cnt, cmp_full;
  logic                ev16, ovf_set, ovf_flag, clr16;
  logic [1:0]          ld_en, clr_en, inc_en, tog_ev, tog_q;
  logic [BYTE_W-1:0]   ld_val [2];
  logic [BYTE_W-1:0]   cnt    [2];

  assign addr_e  = reg_addr_e'(addr_i);
  assign split   = hsel_q[SEL_W-1];
  assign tick_lo = tick_i[lsel_q];
  assign tick_hi = tick_i[hsel_q];
  assign wr_hi   = wr_en_i && (addr_e == REG_CNT_HI);
  assign wr_lo   = wr_en_i && (addr_e == REG_CNT_LO);
  assign rd_hi   = rd_en_i && (addr_e == REG_CNT_HI);
  assign wr_stat = wr_en_i && (addr_e == REG_STAT);
  assign rd_stat = rd_en_i && (addr_e == REG_STAT);

  assign full_cnt = {cnt[1], cnt[0]};
  assign cmp_full = {cmp_h_q, cmp_l_q};
  assign ev16     = !split && tick_lo && !wr_lo && (full_cnt == cmp_full);
  assign clr16    = ev16 && cclr_q;
  assign ovf_set  = !split && tick_lo && !wr_lo && (&full_cnt);

  // per-half controls: index 0 is the low byte, 1 the high byte
  always_comb begin
    ld_en[0]  = wr_lo;
    ld_val[0] = wdata_i;
    clr_en[0] = clr16;
    inc_en[0] = tick_lo;
    ld_en[1]  = split ? wr_hi : wr_lo;
    ld_val[1] = split ? wdata_i : temp_q;
    clr_en[1] = clr16;
    inc_en[1] = split ? tick_hi : (tick_lo && (&cnt[0]));
    tog_ev[0] = split && tick_lo && !wr_lo && (cnt[0] == cmp_l_q);
    tog_ev[1] = split ? (tick_hi && !wr_hi && (cnt[1] == cmp_h_q)) : ev16;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    tbt_count_half #(.W(BYTE_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .load_en  (ld_en[h]),
      .load_val (ld_val[h]),
      .clr_en   (clr_en[h]),
      .inc_en   (inc_en[h]),
      .value    (cnt[h])
    );
    tbt_match_toggle i_tog (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .event_i  (tog_ev[h]),
      .toggle_o (tog_q[h])
    );
  end

  tbt_ovf_status i_stat (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .set_i     (ovf_set),
    .rd_stat_i (rd_stat),
    .wr_stat_i (wr_stat),
    .wr_zero_i (!wdata_i[STAT_OVF_BIT]),
    .ie_i      (ovie_q),
    .irq_en_i  (irq_en_i),
    .flag_o    (ovf_flag),
    .irq_o     (irq_o)
  );

  // configuration and holding register next state
  always_comb begin
    cmp_h_d = cmp_h_q;
    cmp_l_d = cmp_l_q;
    hsel_d  = hsel_q;
    lsel_d  = lsel_q;
    ovie_d  = ovie_q;
    cclr_d  = cclr_q;
    temp_d  = temp_q;
    if (!split && rd_hi) temp_d = cnt[0];
    if (wr_en_i) begin
      case (addr_e)
        REG_CNT_HI: if (!split) temp_d = wdata_i;
        REG_CMP_HI: cmp_h_d = wdata_i;
        REG_CMP_LO: cmp_l_d = wdata_i;
        REG_CTRL: begin
          lsel_d = wdata_i[SEL_W-1:0];
          hsel_d = wdata_i[CTRL_HI_POS +: SEL_W];
        end
        REG_STAT: begin
          ovie_d = wdata_i[STAT_IE_BIT];
          cclr_d = wdata_i[STAT_CCLR_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmp_h_q <= '0;
      cmp_l_q <= '0;
      hsel_q  <= '0;
      lsel_q  <= '0;
      ovie_q  <= 1'b0;
      cclr_q  <= 1'b0;
      temp_q  <= '0;
    end else begin
      cmp_h_q <= cmp_h_d;
      cmp_l_q <= cmp_l_d;
      hsel_q  <= hsel_d;
      lsel_q  <= lsel_d;
      ovie_q  <= ovie_d;
      cclr_q  <= cclr_d;
      temp_q  <= temp_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_e)
      REG_CNT_HI: rdata_o = cnt[1];
      REG_CNT_LO: rdata_o = split ? cnt[0] : temp_q;
      REG_CMP_HI: rdata_o = cmp_h_q;
      REG_CMP_LO: rdata_o = cmp_l_q;
      REG_CTRL: begin
        rdata_o[SEL_W-1:0]           = lsel_q;
        rdata_o[CTRL_HI_POS +: SEL_W] = hsel_q;
      end
      REG_STAT: begin
        rdata_o[STAT_OVF_BIT]  = ovf_flag;
        rdata_o[STAT_IE_BIT]   = ovie_q;
        rdata_o[STAT_CCLR_BIT] = cclr_q;
      end
      default: ;
    endcase
  end

  assign tog_hi_o = tog_q[1];
  assign tog_lo_o = tog_q[0];
endmodule

// File: rtl/tbt_checker.sv
module tbt_checker #(
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          split,
  input logic          tick_lo,
  input logic          wr_lo,
  input logic          cclr,
  input logic [FW-1:0] full_cnt,
  input logic [FW-1:0] cmp_full,
  input logic [FW/2-1:0] temp,
  input logic [FW/2-1:0] wdata,
  input logic          ovf_flag,
  input logic          ovie,
  input logic          irq_en,
  input logic          irq,
  input logic          tog_hi
);
  // R2: plain 16-bit increment
  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && tick_lo && !wr_lo && !(cclr && full_cnt == cmp_full) && !(&full_cnt))
    |=> full_cnt == $past(full_cnt) + FW'(1));

  // R4: clear on compare match
  a_r4_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && tick_lo && !wr_lo && cclr && full_cnt == cmp_full) |=> full_cnt == '0);

  // R5: wrap sets the flag
  a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && tick_lo && !wr_lo && (&full_cnt)) |=> ovf_flag);

  // R7: request only with all qualifiers
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag && ovie && irq_en));

  // R9 and R11: low write loads both bytes, overriding a strobe
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && wr_lo) |=> full_cnt == {$past(temp), $past(wdata)});

  // R10: 16-bit match toggles the high pin
  a_r10_toggle16: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && tick_lo && !wr_lo && full_cnt == cmp_full) |=> tog_hi != $past(tog_hi));
endmodule

bind twin_byte_timer tbt_checker #(.FW(16)) i_tbt_checker (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .split    (split),
  .tick_lo  (tick_lo),
  .wr_lo    (wr_lo),
  .cclr     (cclr_q),
  .full_cnt (full_cnt),
  .cmp_full (cmp_full),
  .temp     (temp_q),
  .wdata    (wdata_i),
  .ovf_flag (ovf_flag),
  .ovie     (ovie_q),
  .irq_en   (irq_en_i),
  .irq      (irq_o),
  .tog_hi   (tog_hi_o)
);

// File: tb/test_twin_byte_timer.sv
module test_twin_byte_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tick;
  logic       irq_en, wr_en, rd_en;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic       irq, tog_hi, tog_lo;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model
  logic [7:0] m_hi, m_lo, m_temp, m_cmph, m_cmpl;
  logic [2:0] m_hsel, m_lsel;
  logic       m_ovie, m_cclr, m_flag, m_armed, m_th, m_tl;

  always #5 clk = ~clk;

  twin_byte_timer i_twin_byte_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .irq_en_i(irq_en),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .tog_hi_o(tog_hi), .tog_lo_o(tog_lo)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic bit m_split();
    return m_hsel[2];
  endfunction

  function automatic void model_tick(input int idx);
    logic [15:0] c;
    if (!m_split()) begin
      if (idx == int'(m_lsel)) begin
        c = {m_hi, m_lo};
        if (c == {m_cmph, m_cmpl}) m_th = ~m_th;
        if (c == 16'hFFFF) m_flag = 1'b1;
        if (m_cclr && c == {m_cmph, m_cmpl}) c = 16'h0000;
        else c = c + 16'd1;
        {m_hi, m_lo} = c;
      end
    end else begin
      if (idx == int'(m_hsel)) begin
        if (m_hi == m_cmph) m_th = ~m_th;
        m_hi = m_hi + 8'd1;
      end
      if (idx == int'(m_lsel)) begin
        if (m_lo == m_cmpl) m_tl = ~m_tl;
        m_lo = m_lo + 8'd1;
      end
    end
  endfunction

  function automatic void model_write(input logic [2:0] a, input logic [7:0] d);
    case (a)
      3'd0: if (m_split()) m_hi = d; else m_temp = d;
      3'd1: if (m_split()) m_lo = d; else {m_hi, m_lo} = {m_temp, d};
      3'd2: m_cmph = d;
      3'd3: m_cmpl = d;
      3'd4: begin m_lsel = d[2:0]; m_hsel = d[6:4]; end
      3'd5: begin
        if (m_armed && !d[7]) m_flag = 1'b0;
        m_armed = 1'b0;
        m_ovie = d[1];
        m_cclr = d[0];
      end
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] model_read(input logic [2:0] a);
    logic [7:0] v;
    v = 8'h00;
    case (a)
      3'd0: begin v = m_hi; if (!m_split()) m_temp = m_lo; end
      3'd1: v = m_split() ? m_lo : m_temp;
      3'd2: v = m_cmph;
      3'd3: v = m_cmpl;
      3'd4: v = {1'b0, m_hsel, 1'b0, m_lsel};
      3'd5: begin v = {m_flag, 5'b0, m_ovie, m_cclr}; if (m_flag) m_armed = 1'b1; end
      default: ;
    endcase
    return v;
  endfunction

  task automatic step(input bit w, input logic [2:0] a, input logic [7:0] d,
                      input bit r, input int tidx, output logic [7:0] rv);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick = 8'h00;
    if (tidx >= 0) tick[tidx] = 1'b1;
    #1 rv = rdata;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; tick = 8'h00;
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] rv;
    model_write(a, d);
    step(1'b1, a, d, 1'b0, -1, rv);
  endtask

  task automatic do_rd(input logic [2:0] a, input string req);
    logic [7:0] rv, ev;
    ev = model_read(a);
    step(1'b0, a, 8'h00, 1'b1, -1, rv);
    chk(req, {8'h00, rv}, {8'h00, ev});
  endtask

  task automatic pulse(input int idx, input string req);
    logic [7:0] rv;
    model_tick(idx);
    step(1'b0, 3'd0, 8'h00, 1'b0, idx, rv);
    chk(req, {14'h0, tog_hi, tog_lo}, {14'h0, m_th, m_tl});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    rst_n = 1'b0; tick = 8'h00; irq_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = 3'd0; wdata = 8'h00;
    m_hi = 0; m_lo = 0; m_temp = 0; m_cmph = 0; m_cmpl = 0; m_hsel = 0; m_lsel = 0;
    m_ovie = 0; m_cclr = 0; m_flag = 0; m_armed = 0; m_th = 0; m_tl = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1: reset state
    chk("R1 pins", {13'h0, irq, tog_hi, tog_lo}, 16'h0000);
    for (int a = 0; a < 6; a++) do_rd(3'(a), "R1 register");

    // R2 R8 R10: 16-bit sweep with compare 0x0123
    do_wr(3'd2, 8'h01);
    do_wr(3'd3, 8'h23);
    do_wr(3'd4, 8'h00);
    for (int i = 0; i < 700; i++) begin
      pulse(0, "R10 16-bit toggle");
      if (i % 50 == 49) begin
        do_rd(3'd0, "R8 high read");
        do_rd(3'd1, "R8 latched low read");
      end
    end
    pulse(3, "R2 foreign strobe pin");
    do_rd(3'd0, "R2 foreign strobe ignored");
    do_rd(3'd1, "R2 foreign strobe ignored");

    // R9 R5 R7 R6
    do_wr(3'd0, 8'hFF);
    do_wr(3'd1, 8'hFE);
    do_rd(3'd0, "R9 coherent load");
    do_rd(3'd1, "R9 coherent load");
    pulse(0, "R5 pin");
    pulse(0, "R5 pin");
    chk("R7 ie off", {15'h0, irq}, 16'h0000);
    do_wr(3'd5, 8'h02);
    chk("R7 ext enable off", {15'h0, irq}, 16'h0000);
    irq_en = 1'b1;
    #1 chk("R6 write without read keeps flag", {15'h0, irq}, 16'h0001);
    irq_en = 1'b0;
    #1 chk("R7 ext enable gates", {15'h0, irq}, 16'h0000);
    irq_en = 1'b1;
    do_rd(3'd5, "R5 flag read");
    do_wr(3'd5, 8'h02);
    chk("R6 clear after read", {15'h0, irq}, {15'h0, m_flag});
    do_rd(3'd5, "R6 flag cleared");
    do_wr(3'd0, 8'hFF);
    do_wr(3'd1, 8'hFF);
    pulse(0, "R5 pin");
    do_wr(3'd0, 8'hFF);
    do_wr(3'd1, 8'hFF);
    do_rd(3'd5, "R6 arm");
    model_tick(0);
    m_armed = 1'b0; m_ovie = 1'b1; m_cclr = 1'b0;
    step(1'b1, 3'd5, 8'h02, 1'b0, 0, rv);
    chk("R6 set wins over clear", {15'h0, irq}, 16'h0001);
    do_rd(3'd5, "R6 set wins status");
    do_rd(3'd0, "R5 wrapped high");
    do_rd(3'd1, "R5 wrapped low");

    // R4: clear on match at 0x0005
    do_wr(3'd5, 8'h01);
    do_wr(3'd2, 8'h00);
    do_wr(3'd3, 8'h05);
    do_wr(3'd0, 8'h00);
    do_wr(3'd1, 8'h00);
    for (int i = 0; i < 20; i++) begin
      pulse(0, "R4 toggle");
      do_rd(3'd0, "R4 high");
      do_rd(3'd1, "R4 low");
    end

    // R11 in 16-bit mode: low write with strobe
    do_wr(3'd5, 8'h00);
    do_wr(3'd0, 8'h12);
    model_write(3'd1, 8'h34);
    step(1'b1, 3'd1, 8'h34, 1'b0, 0, rv);
    chk("R11 16-bit load wins pin", {14'h0, tog_hi, tog_lo}, {14'h0, m_th, m_tl});
    do_rd(3'd0, "R11 16-bit load wins");
    do_rd(3'd1, "R11 16-bit load wins");

    // R3: split mode, high on strobe 5, low on strobe 1
    do_wr(3'd4, 8'h51);
    do_rd(3'd4, "R3 control");
    do_wr(3'd2, 8'h11);
    do_wr(3'd3, 8'h02);
    do_wr(3'd0, 8'h10);
    do_wr(3'd1, 8'hFA);
    for (int i = 0; i < 600; i++) begin
      pulse((i % 3 == 0) ? 5 : 1, "R10 split toggle");
      if (i % 25 == 24) begin
        do_rd(3'd0, "R3 high byte");
        do_rd(3'd1, "R3 low byte");
      end
    end
    do_rd(3'd5, "R3 no 16-bit flag in split");

    // R11 in split mode
    model_write(3'd0, 8'h40);
    step(1'b1, 3'd0, 8'h40, 1'b0, 5, rv);
    do_rd(3'd0, "R11 split load wins");
    do_rd(3'd1, "R11 split low untouched");

    finish_run();
  end
endmodule